// File: doc/BRIEF.md
# Element-Group Vector Length and Legality Unit

This unit sits next to a vector engine's configuration state and answers two questions. Given a requested application vector length, what vector length is granted? Given an instruction that works on fixed-size element groups, may it issue? A configuration strobe turns the requested length into a granted length and holds it. The grant never leaves a partial element group at the end of a stripmine pass when the full register capacity is used.

A check strobe evaluates one instruction's static fields against three things: the held length, the current element-width setting and the current register-grouping setting. The fields are the log2 of the group size, an optional fixed element width, and one flag per operand that marks the operand as a vector of groups. The check reports an illegal-instruction flag or a reserved-length flag.

Every size involved is a power of two. VLMAX, group widths and alignment are therefore all computed with shifts, masks and exponent compares. The results are registered, and a one-cycle valid pulse accompanies each update.

Top module: `eg_vl_unit`

## Requirements
- R1: While reset is held and right after it, `vl_out` is 0, `illegal_out` and `reserved_out` are 0, and `out_valid` is 0.
- R2: The element width code `sew` selects 8<<code bits (0=8, 1=16, 2=32, 3=64). `lmul` is a signed log2 multiplier from -3 to +3. VLMAX = VLEN·2^lmul / (8<<sew), truncated to an integer. On a configuration, a requested length at or below VLMAX is granted unchanged.
- R3: A request above VLMAX is granted VLMAX when VLMAX is a multiple of the largest supported group size 2^LOG2_EGS_MAX.
- R4: Otherwise, a request above VLMAX gets VLMAX rounded down to a multiple of that largest group size. If the rounding would give zero, VLMAX itself is granted. When VLMAX truncates to 0, the grant is 0.
- R5: A check is illegal when the group exponent exceeds LOG2_EGS_MAX, when the group size 2^exp exceeds VLMAX, or when VLMAX is 0.
- R6: The per-element width of the group is the fixed width code `chk_static_eew` (same encoding as `sew`) when `chk_static_en` is 1. Otherwise it is `sew`. A fixed width makes `sew` irrelevant to the width test.
- R7: The group width is 2^exp times the element width. A group wider than VLEN is illegal unless WIDE_GROUP_OK is 1, `lmul` is positive, and the width is at most VLEN·2^lmul.
- R8: `reserved_out` is 1 only when the check is not illegal, at least one `chk_grp_ops` bit is set, and the held vl is not a multiple of 2^exp. With no operand bit set, it is 0.
- R9: Results appear one cycle after a strobe, with `out_valid` high for exactly that cycle. A check leaves `vl_out` unchanged. A lone configuration clears both flags. Without a strobe, `out_valid` stays 0 and the outputs hold.
- R10: When both strobes arrive together, the check uses the vl held before that cycle, and `vl_out` takes the new grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Configuration strobe |
| cfg_avl | input | AVL_W | Requested application vector length |
| sew | input | 2 | Current element width code |
| lmul | input | 3 | Current signed log2 register-grouping multiplier |
| chk_req | input | 1 | Instruction check strobe |
| chk_egs_log2 | input | 3 | Log2 of the instruction's group size |
| chk_static_en | input | 1 | Instruction carries a fixed element width |
| chk_static_eew | input | 2 | Fixed element width code |
| chk_grp_ops | input | N_OPS | Per-operand flag: operand is a vector of groups |
| vl_out | output | AVL_W | Held granted vector length |
| illegal_out | output | 1 | Illegal-instruction result of last check |
| reserved_out | output | 1 | Reserved-length result of last check |
| out_valid | output | 1 | One-cycle pulse with each update |

## Verification
The assertions assume that `lmul` stays within -3 to +3, because the pattern -4 has no meaning. They also assume that the strobes and their fields are free of unknowns whenever reset is released. Every directed stimulus drives only in-range multipliers and width codes. Every stimulus sets all fields before raising a strobe at the falling edge. The stimulus reaches both the case where the exponent compare against VLMAX fails and the case where the capacity compare fails. The assertions on the grant therefore see configurations with VLMAX below, equal to and above the largest group size, and one configuration whose VLMAX truncates to zero.

// File: rtl/eg_vl_pkg.sv
package eg_vl_pkg;

   // element width code: width in bits = 8 << code
   typedef logic [1:0] ew_code_t;

   // signed log2 of the register grouping multiplier
   typedef logic signed [2:0] lmul_exp_t;

   // exponent arithmetic is carried at this width, signed
   localparam int EXP_W = 8;
   typedef logic signed [EXP_W-1:0] exp_t;

   typedef struct packed {
      logic illegal;
      logic reserved;
   } chk_flags_t;

endpackage

// File: rtl/eg_vlmax_calc.sv
module eg_vlmax_calc
   import eg_vl_pkg::*;
#(
   parameter int VLEN = 128,
   localparam int LOG2_VLEN = $clog2(VLEN),
   localparam int VM_W = LOG2_VLEN + 1
) (
   input  ew_code_t         sew,
   input  lmul_exp_t        lmul,
   output exp_t             vlmax_exp,
   output logic             vlmax_zero,
   output logic [VM_W-1:0]  vlmax
);

   exp_t lmul_ext;
   exp_t sew_ext;

   always_comb begin
      lmul_ext   = exp_t'(lmul);
      sew_ext    = exp_t'({1'b0, sew});
      // log2(VLEN * 2^lmul / (8 << sew))
      vlmax_exp  = exp_t'(LOG2_VLEN) + lmul_ext - exp_t'(3) - sew_ext;
      vlmax_zero = vlmax_exp[EXP_W-1];
      if (vlmax_zero) begin
         vlmax = '0;
      end else begin
         vlmax = VM_W'(1) << vlmax_exp[EXP_W-2:0];
      end
   end

endmodule

// File: rtl/eg_vl_grant.sv
module eg_vl_grant #(
   parameter int VLEN        = 128,
   parameter int AVL_W       = 16,
   parameter int LOG2_EGS_MAX = 3,
   localparam int LOG2_VLEN  = $clog2(VLEN),
   localparam int VM_W       = LOG2_VLEN + 1,
   localparam int EGS_MAX    = 1 << LOG2_EGS_MAX
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AVL_W-1:0]  avl,
   input  logic [VM_W-1:0]   vlmax,
   output logic [AVL_W-1:0]  grant
);

   logic [AVL_W-1:0] vlmax_w;
   logic             over;

   assign vlmax_w = AVL_W'(vlmax);
   assign over    = avl > vlmax_w;

   if (LOG2_EGS_MAX == 0) begin : g_plain
      // groups of one element: ordinary clamp
      assign grant = over ? vlmax_w : avl;
   end else begin : g_grouped
      localparam logic [AVL_W-1:0] GRP_MASK = AVL_W'(EGS_MAX - 1);
      logic [AVL_W-1:0] rounded;

      always_comb begin
         rounded = vlmax_w & ~GRP_MASK;
         if (!over) begin
            grant = avl;
         end else if (rounded == vlmax_w || rounded == '0) begin
            grant = vlmax_w;
         end else begin
            grant = rounded;
         end
      end

      // a capped grant of at least one largest group is whole groups (R3, R4)
      p_whole_groups_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (over && vlmax_w >= AVL_W'(EGS_MAX)) |-> ((grant & GRP_MASK) == '0))
         else $error("capped grant splits a group");

      // a capped grant is never zero unless VLMAX is (R4)
      p_nonzero_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (over && vlmax_w != '0) |-> (grant != '0 && grant <= vlmax_w))
         else $error("capped grant out of range");
   end

endmodule

// File: rtl/eg_legal_check.sv
module eg_legal_check
   import eg_vl_pkg::*;
#(
   parameter int VLEN          = 128,
   parameter int AVL_W         = 16,
   parameter int LOG2_EGS_MAX  = 3,
   parameter int N_OPS         = 3,
   parameter bit WIDE_GROUP_OK = 1'b1,
   localparam int LOG2_VLEN    = $clog2(VLEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ew_code_t          sew,
   input  lmul_exp_t         lmul,
   input  exp_t              vlmax_exp,
   input  logic              vlmax_zero,
   input  logic [2:0]        egs_log2,
   input  logic              static_en,
   input  ew_code_t          static_eew,
   input  logic [N_OPS-1:0]  grp_ops,
   input  logic [AVL_W-1:0]  vl_held,
   output chk_flags_t        flags
);

   ew_code_t          eew_code;
   logic [7:0]        egw_log2;
   logic              unsupported;
   logic              exceeds_vlmax;
   logic              too_wide;
   logic [AVL_W-1:0]  egs_mask;
   logic              misaligned;
   logic [N_OPS-1:0]  op_bad;
   logic              illegal;

   assign eew_code = static_en ? static_eew : sew;
   // log2 of group width in bits: egs_log2 + log2(8 << eew)
   assign egw_log2 = {5'b0, egs_log2} + 8'd3 + {6'b0, eew_code};

   assign unsupported   = 32'(egs_log2) > LOG2_EGS_MAX;
   assign exceeds_vlmax = vlmax_zero || (exp_t'({5'b0, egs_log2}) > vlmax_exp);

   if (WIDE_GROUP_OK) begin : g_wide
      logic [1:0] lmul_pos;
      logic [7:0] cap_log2;
      assign lmul_pos = lmul[2] ? 2'd0 : lmul[1:0];
      assign cap_log2 = 8'(LOG2_VLEN) + {6'b0, lmul_pos};
      assign too_wide = egw_log2 > cap_log2;
   end else begin : g_narrow
      assign too_wide = egw_log2 > 8'(LOG2_VLEN);
   end

   assign illegal = unsupported || exceeds_vlmax || too_wide;

   assign egs_mask   = AVL_W'((32'd1 << egs_log2) - 32'd1);
   assign misaligned = |(vl_held & egs_mask);

   for (genvar i = 0; i < N_OPS; i++) begin : g_op
      assign op_bad[i] = grp_ops[i] && misaligned;
   end

   assign flags.illegal  = illegal;
   assign flags.reserved = !illegal && (|op_bad);

   // a group size beyond the supported limit is always illegal (R5)
   p_unsupported_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(egs_log2) > LOG2_EGS_MAX) |-> flags.illegal)
      else $error("unsupported group size accepted");

   // reserved only with a flagged operand and a misaligned vl (R8)
   p_reserved_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flags.reserved |-> (grp_ops != '0 && (vl_held & egs_mask) != '0))
      else $error("reserved without cause");

endmodule

// File: rtl/eg_vl_unit.sv
module eg_vl_unit
   import eg_vl_pkg::*;
#(
   parameter int VLEN          = 128,
   parameter int AVL_W         = 16,
   parameter int LOG2_EGS_MAX  = 3,
   parameter int N_OPS         = 3,
   parameter bit WIDE_GROUP_OK = 1'b1,
   localparam int LOG2_VLEN    = $clog2(VLEN),
   localparam int VM_W         = LOG2_VLEN + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_req,
   input  logic [AVL_W-1:0]  cfg_avl,
   input  logic [1:0]        sew,
   input  logic [2:0]        lmul,
   input  logic              chk_req,
   input  logic [2:0]        chk_egs_log2,
   input  logic              chk_static_en,
   input  logic [1:0]        chk_static_eew,
   input  logic [N_OPS-1:0]  chk_grp_ops,
   output logic [AVL_W-1:0]  vl_out,
   output logic              illegal_out,
   output logic              reserved_out,
   output logic              out_valid
);

   // elaboration-time parameter checks
   if ((1 << LOG2_VLEN) != VLEN) begin : g_bad_vlen
      $error("VLEN must be a power of two");
   end
   if (AVL_W <= LOG2_VLEN) begin : g_bad_avl
      $error("AVL_W too narrow to hold VLMAX");
   end
   if (LOG2_EGS_MAX < 0 || LOG2_EGS_MAX > 7) begin : g_bad_egs
      $error("LOG2_EGS_MAX must fit the 3-bit group field");
   end
   if (N_OPS < 1) begin : g_bad_ops
      $error("N_OPS must be at least 1");
   end

   exp_t             vlmax_exp;
   logic             vlmax_zero;
   logic [VM_W-1:0]  vlmax;
   logic [AVL_W-1:0] grant;
   chk_flags_t       chk_flags;

   logic [AVL_W-1:0] vl_q;
   chk_flags_t       flags_q;
   logic             valid_q;

   eg_vlmax_calc #(.VLEN(VLEN)) u_vlmax (
      .sew        (ew_code_t'(sew)),
      .lmul       (lmul_exp_t'(lmul)),
      .vlmax_exp  (vlmax_exp),
      .vlmax_zero (vlmax_zero),
      .vlmax      (vlmax)
   );

   eg_vl_grant #(
      .VLEN        (VLEN),
      .AVL_W       (AVL_W),
      .LOG2_EGS_MAX(LOG2_EGS_MAX)
   ) u_grant (
      .clk   (clk),
      .rst_n (rst_n),
      .avl   (cfg_avl),
      .vlmax (vlmax),
      .grant (grant)
   );

   eg_legal_check #(
      .VLEN         (VLEN),
      .AVL_W        (AVL_W),
      .LOG2_EGS_MAX (LOG2_EGS_MAX),
      .N_OPS        (N_OPS),
      .WIDE_GROUP_OK(WIDE_GROUP_OK)
   ) u_check (
      .clk        (clk),
      .rst_n      (rst_n),
      .sew        (ew_code_t'(sew)),
      .lmul       (lmul_exp_t'(lmul)),
      .vlmax_exp  (vlmax_exp),
      .vlmax_zero (vlmax_zero),
      .egs_log2   (chk_egs_log2),
      .static_en  (chk_static_en),
      .static_eew (ew_code_t'(chk_static_eew)),
      .grp_ops    (chk_grp_ops),
      .vl_held    (vl_q),
      .flags      (chk_flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vl_q    <= '0;
         flags_q <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= cfg_req || chk_req;
         if (cfg_req) begin
            vl_q <= grant;
         end
         if (chk_req) begin
            flags_q <= chk_flags;
         end else if (cfg_req) begin
            flags_q <= '0;
         end
      end
   end

   assign vl_out       = vl_q;
   assign illegal_out  = flags_q.illegal;
   assign reserved_out = flags_q.reserved;
   assign out_valid    = valid_q;

   // each strobe yields a valid pulse one cycle later (R9)
   p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req || chk_req) |=> out_valid)
      else $error("missing valid pulse");

   // no strobe, no pulse, outputs held (R9)
   p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_req || chk_req) |=> (!out_valid && $stable(vl_out)
                                 && $stable(illegal_out) && $stable(reserved_out)))
      else $error("outputs moved without strobe");

   // a lone check never changes the held length (R9)
   p_check_keeps_vl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_req && !cfg_req) |=> $stable(vl_out))
      else $error("check altered vl");

   // the grant never exceeds the request (R2)
   p_grant_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |=> (vl_out <= $past(cfg_avl)))
      else $error("grant above request");

   // the two flags are never raised together (R8)
   p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(illegal_out && reserved_out))
      else $error("illegal and reserved both set");

endmodule

// File: tb/eg_vl_unit_tb_top.sv
module eg_vl_unit_tb_top;

   localparam int VLEN  = 128;
   localparam int AVL_W = 16;
   localparam int LEM   = 3;
   localparam int N_OPS = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_req = 1'b0;
   logic [AVL_W-1:0] cfg_avl = '0;
   logic [1:0]       sew = '0;
   logic [2:0]       lmul = '0;
   logic             chk_req = 1'b0;
   logic [2:0]       chk_egs_log2 = '0;
   logic             chk_static_en = 1'b0;
   logic [1:0]       chk_static_eew = '0;
   logic [N_OPS-1:0] chk_grp_ops = '0;
   logic [AVL_W-1:0] vl_out;
   logic             illegal_out;
   logic             reserved_out;
   logic             out_valid;

   int n_checks = 0;
   int n_fails  = 0;
   int held_vl  = 0;

   always #2.5 clk = ~clk;

   eg_vl_unit #(
      .VLEN(VLEN), .AVL_W(AVL_W), .LOG2_EGS_MAX(LEM),
      .N_OPS(N_OPS), .WIDE_GROUP_OK(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_avl(cfg_avl),
      .sew(sew), .lmul(lmul), .chk_req(chk_req), .chk_egs_log2(chk_egs_log2),
      .chk_static_en(chk_static_en), .chk_static_eew(chk_static_eew),
      .chk_grp_ops(chk_grp_ops), .vl_out(vl_out), .illegal_out(illegal_out),
      .reserved_out(reserved_out), .out_valid(out_valid)
   );

   // ---------------- reference model from the requirements ----------------
   function automatic int m_vlmax(int s, int l);
      int num, den;
      num = VLEN * (1 << (l + 3));
      den = 8 * (8 << s);
      return num / den;
   endfunction

   function automatic int m_grant(int avl, int s, int l);
      int vm, r;
      vm = m_vlmax(s, l);
      if (avl <= vm) return avl;
      if (vm % (1 << LEM) == 0) return vm;
      r = (vm / (1 << LEM)) * (1 << LEM);
      return (r == 0) ? vm : r;
   endfunction

   function automatic bit m_illegal(int e, int s, int l, bit st, int sv);
      int vm, ew, egw;
      vm  = m_vlmax(s, l);
      ew  = 8 << (st ? sv : s);
      egw = (1 << e) * ew;
      if (e > LEM) return 1'b1;
      if (vm == 0 || (1 << e) > vm) return 1'b1;
      if (egw > VLEN && !(l > 0 && egw <= VLEN * (1 << l))) return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit m_reserved(int e, int s, int l, bit st, int sv,
                                     int ops, int vl);
      if (m_illegal(e, s, l, st, sv)) return 1'b0;
      return (ops != 0) && (vl % (1 << e) != 0);
   endfunction

   // ---------------- checking helper ----------------
   task automatic expect_eq(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_cfg(string req, int avl, int s, int l);
      int exp_vl;
      exp_vl = m_grant(avl, s, l);
      @(negedge clk);
      cfg_avl = AVL_W'(avl); sew = 2'(s); lmul = 3'(l); cfg_req = 1'b1;
      @(negedge clk);
      cfg_req = 1'b0;
      expect_eq(req, "valid", int'(out_valid), 1);
      expect_eq(req, "vl", int'(vl_out), exp_vl);
      expect_eq(req, "flags cleared", int'({illegal_out, reserved_out}), 0);
      held_vl = exp_vl;
   endtask

   task automatic do_chk(string req, int e, bit st, int sv, int ops);
      int s, l;
      s = int'(sew);
      l = int'($signed(lmul));
      @(negedge clk);
      chk_egs_log2 = 3'(e); chk_static_en = st; chk_static_eew = 2'(sv);
      chk_grp_ops = N_OPS'(ops); chk_req = 1'b1;
      @(negedge clk);
      chk_req = 1'b0;
      expect_eq(req, "valid", int'(out_valid), 1);
      expect_eq(req, "illegal", int'(illegal_out), int'(m_illegal(e, s, l, st, sv)));
      expect_eq(req, "reserved", int'(reserved_out),
                int'(m_reserved(e, s, l, st, sv, ops, held_vl)));
      expect_eq(req, "vl kept", int'(vl_out), held_vl);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      repeat (3) @(negedge clk);
      expect_eq("R1", "vl in reset", int'(vl_out), 0);
      expect_eq("R1", "flags in reset", int'({illegal_out, reserved_out}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      expect_eq("R1", "valid after reset", int'(out_valid), 0);
      expect_eq("R1", "vl after reset", int'(vl_out), 0);
   endtask

   task automatic t_grant_fits;
      do_cfg("R2", 3, 2, 0);
      do_cfg("R2", 4, 2, 0);
      do_cfg("R2", 20, 0, 1);
      do_cfg("R2", 2, 0, -1);
      do_cfg("R2", 0, 1, 2);
   endtask

   task automatic t_grant_cap;
      do_cfg("R3", 100, 0, 3);
      do_cfg("R3", 50, 2, 1);
      do_cfg("R3", 65535, 1, 0);
   endtask

   task automatic t_grant_small;
      do_cfg("R4", 10, 3, 1);
      do_cfg("R4", 5, 2, -1);
      do_cfg("R4", 9, 3, -3);
      expect_eq("R4", "zero vlmax grant", int'(vl_out), 0);
   endtask

   task automatic t_egs_limit;
      do_cfg("R5", 4, 2, 0);
      do_chk("R5", 2, 1'b0, 0, 1);
      do_chk("R5", 3, 1'b0, 0, 1);
      do_cfg("R5", 100, 0, 3);
      do_chk("R5", 4, 1'b0, 0, 0);
      do_chk("R5", 7, 1'b0, 0, 0);
      do_cfg("R5", 9, 3, -3);
      do_chk("R5", 0, 1'b0, 0, 0);
   endtask

   task automatic t_static_width;
      do_cfg("R6", 16, 0, 0);
      do_chk("R6", 2, 1'b0, 0, 1);
      do_chk("R6", 2, 1'b1, 3, 1);
      do_cfg("R6", 2, 3, 0);
      do_chk("R6", 1, 1'b1, 0, 1);
      do_chk("R6", 2, 1'b1, 0, 1);
   endtask

   task automatic t_wide;
      do_cfg("R7", 8, 2, 1);
      do_chk("R7", 3, 1'b0, 0, 1);
      do_chk("R7", 3, 1'b1, 3, 1);
      do_cfg("R7", 4, 2, 0);
      do_chk("R7", 2, 1'b1, 3, 0);
      do_chk("R7", 2, 1'b0, 0, 0);
   endtask

   task automatic t_reserved;
      do_cfg("R8", 6, 2, 1);
      do_chk("R8", 2, 1'b0, 0, 2);
      do_chk("R8", 2, 1'b0, 0, 0);
      do_chk("R8", 1, 1'b0, 0, 4);
      do_chk("R8", 3, 1'b0, 0, 7);
      do_chk("R8", 3, 1'b1, 3, 1);
      expect_eq("R8", "illegal masks reserved", int'(reserved_out), 0);
   endtask

   task automatic t_both;
      do_cfg("R10", 6, 2, 1);
      @(negedge clk);
      cfg_avl = 16'd8; cfg_req = 1'b1;
      chk_egs_log2 = 3'd2; chk_static_en = 1'b0; chk_grp_ops = 3'b001;
      chk_req = 1'b1;
      @(negedge clk);
      cfg_req = 1'b0; chk_req = 1'b0;
      expect_eq("R10", "check saw old vl", int'(reserved_out), 1);
      expect_eq("R10", "new vl", int'(vl_out), 8);
      held_vl = 8;
      do_chk("R10", 2, 1'b0, 0, 1);
   endtask

   task automatic t_idle;
      do_cfg("R9", 6, 2, 1);
      do_chk("R9", 2, 1'b0, 0, 1);
      @(negedge clk);
      expect_eq("R9", "no pulse idle", int'(out_valid), 0);
      expect_eq("R9", "flag held idle", int'(reserved_out), 1);
      expect_eq("R9", "vl held idle", int'(vl_out), 6);
      do_cfg("R9", 8, 2, 1);
   endtask

   initial begin
      t_reset();
      t_grant_fits();
      t_grant_cap();
      t_grant_small();
      t_egs_limit();
      t_static_width();
      t_wide();
      t_reserved();
      t_both();
      t_idle();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule